// File: doc/BRIEF.md
# Client Isolation and Quiesce Controller

This block sits between fifteen memory clients and a shared memory port. For each client it holds a traffic-allow bit and an active-low hot-reset bit. It also keeps an outstanding-request counter, which goes up on every issue the fabric accepts and down on every completion the fabric returns. A client whose allow bit is clear has its request valid forced low before the fabric sees it. Completions for requests it issued earlier still drain and are still counted.

Software isolates a client with a fixed sequence:
1. Clear the client's allow bit.
2. Poll the client's status word until it reads zero.
3. Clear the client's reset bit.
4. Later, set the reset bit again.
5. Set the allow bit again.

Each register is written as a whole word. Software does a read-modify-write so that the bits of the other clients stay as they were.

Top module: `qsc_client_isolator`

## Requirements
- R1: After power-on reset the allow word and the reset word both read 0x7FFF, every `clientResetN` bit is 1, and every status word reads 0.
- R2: The allow word is at word address 0 and the reset word is at word address 1. The status of client k is at word address 2+k. Bit k of the allow word and of the reset word belongs to client k. Bits 15 and above read 0, and addresses 17 to 31 read 0. A write replaces the whole word, and a read reflects the write from the next cycle on.
- R3: `fabricReqValid[k]` equals `clientReqValid[k]` AND allow bit k, with no register in the path.
- R4: An accepted issue (`fabricReqValid[k]` and `fabricReqReady[k]` both high) with no completion raises client k's status by one, visible the cycle after.
- R5: A completion with no accepted issue lowers the status by one. An accepted issue and a completion in the same cycle leave the status unchanged.
- R6: A completion on a client whose allow bit is clear still decrements that client's status. A blocked client's request adds nothing to its count, even while `fabricReqReady` is high.
- R7: `clientResetN[k]` follows reset bit k, so writing 0 to the bit holds client k in reset and writing 1 releases it. The other clients' outputs are unaffected.
- R8: The status saturates at 255 (2^CNT_W-1), and further issues are not counted. A completion when the status is 0 leaves it at 0.
- R9: Writes to status addresses have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from `regAddr` |
| clientReqValid | input | 15 | Per-client request valid from the clients |
| fabricReqReady | input | 15 | Per-client accept from the fabric |
| fabricReqValid | output | 15 | Gated per-client request valid to the fabric |
| complStrobe | input | 15 | Per-client completion strobe from the fabric |
| clientResetN | output | 15 | Per-client active-low hot reset |

## Verification
The bench targets the following corner cases and the failure each would cause:

- **Same-cycle issue and completion.** A design that gives either event priority would drift the count, so a drained client would never read zero.
- **Completions after blocking.** If completions are gated along with requests, a quiesced client stays stuck at a non-zero count forever.
- **Saturation and underflow.** Without the limits, the counter wraps 255 to 0 (falsely reporting idle) or 0 to 255.
- **Isolation of single bits.** Writing one client's reset bit or a status address must not disturb the other clients' reset outputs or any register; a loose address decode would corrupt them.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

  localparam int ALLOW_OFS   = 0;
  localparam int RESET_OFS   = 1;
  localparam int STATUS_BASE = 2;
  localparam int IDX_W       = 8;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_ALLOW  = 2'd1,
    RD_RESET  = 2'd2,
    RD_STATUS = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic             allowWr;
    logic             resetWr;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] statusIdx;
  } ctrlStrb_t;

endpackage

// File: rtl/qsc_reg_decode.sv
module qsc_reg_decode
  import qsc_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int AW          = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  output ctrlStrb_t     strb
);

  localparam int LAST_STATUS = STATUS_BASE + NUM_CLIENTS - 1;

  logic [AW-1:0] statusOfs;
  logic          inStatus;

  assign statusOfs = regAddr - AW'(STATUS_BASE);
  assign inStatus  = (regAddr >= AW'(STATUS_BASE)) && (regAddr <= AW'(LAST_STATUS));

  always_comb begin
    strb           = '0;
    strb.rdSel     = RD_NONE;
    if (regAddr == AW'(ALLOW_OFS)) begin
      strb.allowWr = regWrEn;
      strb.rdSel   = RD_ALLOW;
    end else if (regAddr == AW'(RESET_OFS)) begin
      strb.resetWr = regWrEn;
      strb.rdSel   = RD_RESET;
    end else if (inStatus) begin
      strb.rdSel     = RD_STATUS;
      strb.statusIdx = IDX_W'(statusOfs);
    end
  end

  // R2: at most one register is written per cycle
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.allowWr, strb.resetWr}));

  // R9: a write to a status address produces no write strobe
  assert_status_ro_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && inStatus) |-> !(strb.allowWr || strb.resetWr));

endmodule

// File: rtl/qsc_outstanding.sv
module qsc_outstanding #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic             compl,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({issue, compl})
        2'b10:   if (count != CNT_MAX) count <= count + 1'b1;
        2'b01:   if (count != '0)      count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_issue_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !compl && count != CNT_MAX) |=> (count != '0));

  assert_balanced_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issue == compl) |=> $stable(count));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX && !compl) |=> (count == CNT_MAX));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !issue) |=> (count == '0));

endmodule

// File: rtl/qsc_datapath.sv
module qsc_datapath
  import qsc_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrb_t              strb,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [NUM_CLIENTS-1:0] clientReqValid,
  input  logic [NUM_CLIENTS-1:0] fabricReqReady,
  input  logic [NUM_CLIENTS-1:0] complStrobe,
  output logic [NUM_CLIENTS-1:0] fabricReqValid,
  output logic [NUM_CLIENTS-1:0] clientResetN,
  output logic [DATA_W-1:0]      rdData
);

  localparam int SEL_W = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;

  logic [NUM_CLIENTS-1:0] allowReg;
  logic [NUM_CLIENTS-1:0] resetReg;
  logic [NUM_CLIENTS-1:0] acceptedIssue;
  logic [CNT_W-1:0]       outCount [NUM_CLIENTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allowReg <= '1;
      resetReg <= '1;
    end else begin
      if (strb.allowWr) allowReg <= wrData[NUM_CLIENTS-1:0];
      if (strb.resetWr) resetReg <= wrData[NUM_CLIENTS-1:0];
    end
  end

  assign fabricReqValid = clientReqValid & allowReg;
  assign acceptedIssue  = fabricReqValid & fabricReqReady;
  assign clientResetN   = resetReg;

  for (genvar k = 0; k < NUM_CLIENTS; k++) begin : gClient
    qsc_outstanding #(.CNT_W(CNT_W)) i_outstanding (
      .clk   (clk),
      .rstN  (rstN),
      .issue (acceptedIssue[k]),
      .compl (complStrobe[k]),
      .count (outCount[k])
    );
  end

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_ALLOW:  rdData = DATA_W'(allowReg);
      RD_RESET:  rdData = DATA_W'(resetReg);
      RD_STATUS: rdData = DATA_W'(outCount[strb.statusIdx[SEL_W-1:0]]);
      default:   rdData = '0;
    endcase
  end

  assert_gate_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.allowWr |=> ((fabricReqValid & ~$past(wrData[NUM_CLIENTS-1:0])) == '0));

  assert_reset_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.resetWr |=> (clientResetN == $past(wrData[NUM_CLIENTS-1:0])));

  assert_reset_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.resetWr |=> $stable(clientResetN));

endmodule

// File: rtl/qsc_client_isolator.sv
module qsc_client_isolator
  import qsc_pkg::*;
#(
  parameter  int NUM_CLIENTS = 15,
  parameter  int CNT_W       = 8,
  parameter  int DATA_W      = 32,
  localparam int AW          = $clog2(STATUS_BASE + NUM_CLIENTS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [AW-1:0]          regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  input  logic [NUM_CLIENTS-1:0] clientReqValid,
  input  logic [NUM_CLIENTS-1:0] fabricReqReady,
  output logic [NUM_CLIENTS-1:0] fabricReqValid,
  input  logic [NUM_CLIENTS-1:0] complStrobe,
  output logic [NUM_CLIENTS-1:0] clientResetN
);

  ctrlStrb_t strb;

  qsc_reg_decode #(.NUM_CLIENTS(NUM_CLIENTS), .AW(AW)) i_decode (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  qsc_datapath #(.NUM_CLIENTS(NUM_CLIENTS), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .wrData         (regWrData),
    .clientReqValid (clientReqValid),
    .fabricReqReady (fabricReqReady),
    .complStrobe    (complStrobe),
    .fabricReqValid (fabricReqValid),
    .clientResetN   (clientResetN),
    .rdData         (regRdData)
  );

endmodule

// File: tb/test_qsc_client_isolator.sv
module test_qsc_client_isolator;

  localparam int N  = 15;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [N-1:0]  clientReqValid = '0;
  logic [N-1:0]  fabricReqReady = '0;
  logic [N-1:0]  fabricReqValid;
  logic [N-1:0]  complStrobe = '0;
  logic [N-1:0]  clientResetN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qsc_client_isolator i_qsc_client_isolator (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .clientReqValid(clientReqValid), .fabricReqReady(fabricReqReady),
    .fabricReqValid(fabricReqValid), .complStrobe(complStrobe),
    .clientResetN(clientResetN)
  );

  // {allow word, client valid, expected fabric valid}
  localparam logic [3*N-1:0] GATE_VEC [6] = '{
    {15'h7FFF, 15'h7FFF, 15'h7FFF},
    {15'h0000, 15'h7FFF, 15'h0000},
    {15'h5555, 15'h7FFF, 15'h5555},
    {15'h7FFF, 15'h2AAA, 15'h2AAA},
    {15'h00F0, 15'h0FF0, 15'h00F0},
    {15'h4001, 15'h4000, 15'h4000}
  };

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [AW-1:0] a, output logic [DW-1:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic drive(logic [N-1:0] v, logic [N-1:0] r, logic [N-1:0] c, int n);
    @(negedge clk);
    clientReqValid = v; fabricReqReady = r; complStrobe = c;
    repeat (n) @(negedge clk);
    clientReqValid = '0; fabricReqReady = '0; complStrobe = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(5'd0, rd); check("R1 allow", rd, 32'h7FFF);
    regRead(5'd1, rd); check("R1 reset", rd, 32'h7FFF);
    check("R1 clientResetN", DW'(clientResetN), 32'h7FFF);
    for (int k = 0; k < N; k++) begin
      regRead(AW'(2 + k), rd); check("R1 status", rd, 32'h0);
    end

    // R3 gating table
    for (int i = 0; i < 6; i++) begin
      regWrite(5'd0, DW'(GATE_VEC[i][3*N-1:2*N]));
      clientReqValid = GATE_VEC[i][2*N-1:N];
      #1 check("R3 gate", DW'(fabricReqValid), DW'(GATE_VEC[i][N-1:0]));
      clientReqValid = '0;
    end

    // R2 whole-word write, upper bits, unmapped addresses
    regWrite(5'd0, 32'hFFFF_FFFF);
    regRead(5'd0, rd); check("R2 upper bits", rd, 32'h7FFF);
    regRead(5'd17, rd); check("R2 unmapped 17", rd, 32'h0);
    regRead(5'd31, rd); check("R2 unmapped 31", rd, 32'h0);

    // R4 accepted issues on client 3
    drive(15'h0008, 15'h0008, 15'h0, 3);
    regRead(5'd5, rd); check("R4 count", rd, 32'd3);
    regRead(5'd4, rd); check("R2 neighbour status", rd, 32'd0);
    drive(15'h0008, 15'h0000, 15'h0, 2);
    regRead(5'd5, rd); check("R4 not accepted", rd, 32'd3);

    // R5 same-cycle and completion
    drive(15'h0008, 15'h0008, 15'h0008, 1);
    regRead(5'd5, rd); check("R5 balanced", rd, 32'd3);
    drive(15'h0, 15'h0, 15'h0008, 1);
    regRead(5'd5, rd); check("R5 decrement", rd, 32'd2);

    // R6 blocked client: no issue, completions drain
    regWrite(5'd0, 32'h7FF7);
    clientReqValid = 15'h0008;
    #1 check("R6 gated", DW'(fabricReqValid[3]), 32'd0);
    drive(15'h0008, 15'h0008, 15'h0, 2);
    regRead(5'd5, rd); check("R6 blocked issue", rd, 32'd2);
    drive(15'h0, 15'h0, 15'h0008, 2);
    regRead(5'd5, rd); check("R6 drained", rd, 32'd0);

    // R7 hot reset of client 3 only
    regWrite(5'd1, 32'h7FF7);
    check("R7 asserted", DW'(clientResetN), 32'h7FF7);
    regRead(5'd1, rd); check("R7 readback", rd, 32'h7FF7);
    regWrite(5'd1, 32'h7FFF);
    check("R7 released", DW'(clientResetN), 32'h7FFF);
    regWrite(5'd0, 32'h7FFF);

    // R8 saturation and underflow
    drive(15'h0001, 15'h0001, 15'h0, 260);
    regRead(5'd2, rd); check("R8 saturate", rd, 32'd255);
    drive(15'h0, 15'h0, 15'h0020, 2);
    regRead(5'd7, rd); check("R8 underflow", rd, 32'd0);

    // R9 writes to status words ignored
    regWrite(5'd2, 32'h0);
    regWrite(5'd3, 32'h0);
    regRead(5'd2, rd); check("R9 status kept", rd, 32'd255);
    regRead(5'd0, rd); check("R9 allow kept", rd, 32'h7FFF);
    regRead(5'd1, rd); check("R9 reset kept", rd, 32'h7FFF);
    check("R9 clientResetN", DW'(clientResetN), 32'h7FFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule